// File: doc/BRIEF.md
# Receive Pause Request Handshake Controller

This block tracks received pause requests on nine independent channels. Channel 8 carries global pause and channels 7 to 0 carry the eight priority classes. Upstream logic has already parsed and classified each pause frame. It presents a one-cycle pulse on the channel's bit together with that channel's 16-bit quanta. The block turns each accepted pause into a request bit towards user logic. Depending on a global mode bit, it can wait for a user acknowledge before timing the pause. It counts the quanta down, drops the request when the count expires, and then waits for the acknowledge to be released, or for a fixed timeout, before the channel goes idle again.

Each channel is a four-state machine:
- `CH_IDLE`: no request.
- `CH_ACK_WAIT`: request high, timer held.
- `CH_COUNT`: request high, timer running.
- `CH_RELEASE`: request low, waiting for the acknowledge to fall.

The transitions are:
- IDLE to ACK_WAIT, on an accepted pause with the check mode at 1.
- IDLE to COUNT, on an accepted pause with the check mode at 0.
- ACK_WAIT to COUNT, on acknowledge high or check mode at 0.
- COUNT to COUNT, on a reload.
- COUNT to RELEASE, on expiry with the check mode at 1.
- COUNT to IDLE, on expiry with the check mode at 0.
- RELEASE to COUNT, on a reload.
- RELEASE to IDLE, on acknowledge low, check mode at 0, or timeout.

One quanta unit lasts `CYCLES_PER_QUANTA` clocks. A single free-running prescaler shared by all channels produces the quanta ticks.

Top module: `rxp_pause_ctrl`

## Requirements
- R1: A synchronous active-high `rst` returns every channel to idle with its timer cleared. On the first cycle after reset, `pause_req` is all zeros. The quanta prescaler restarts at reset.
- R2: A pulse on `pause_rx_vld[i]` while `pause_en[i]` is 0 and `pause_req[i]` is 0 is discarded: `pause_req[i]` stays 0.
- R3: A pulse on `pause_rx_vld[i]` with `pause_en[i]` at 1 makes `pause_req[i]` read 1 on the following cycle, whatever state the channel was in.
- R4: With `ack_check_mode` at 1, a channel whose request has just been raised holds its timer until `pause_ack[i]` is 1. With the mode at 0, the countdown starts at once.
- R5: A quanta tick occurs once every `CYCLES_PER_QUANTA` clocks, counted from reset. At a tick, a counting channel whose timer holds 0 or 1 expires; otherwise its timer decrements by one. `pause_req[i]` reads 0 on the cycle after the expiring tick. A quanta of N ≥ 1 therefore lasts N ticks, and a quanta of 0 lasts one tick.
- R6: After expiry with `ack_check_mode` at 1, the channel goes idle once `pause_ack[i]` is 0. If the acknowledge stays high, the channel goes idle after `RELEASE_CYCLES` (32) cycles with the request low. With the mode at 0, it goes idle directly on expiry.
- R7: An accepted pause while the channel waits for acknowledge, counts, or waits for release reloads the timer with the new quanta. During the release wait, the reload raises the request again and returns the channel straight to counting, with no new acknowledge edge needed.
- R8: Clearing `pause_en[i]` after the channel has left idle does not abort the sequence; it still runs to expiry. Pauses that arrive while the enable is 0 do not reload the timer.
- R9: Channels are independent. Channel i takes its quanta from `pause_rx_quanta[16*i +: 16]`. Bit 8 of every per-channel bus is global pause and bits 7 to 0 are the priority classes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pause_rx_vld | input | 9 | One-cycle pulse per channel: a pause frame was received |
| pause_rx_quanta | input | 144 | Quanta for each channel, 16 bits per channel, channel i at [16*i +: 16] |
| pause_en | input | 9 | Per-channel acceptance enable |
| ack_check_mode | input | 1 | 1: wait for user acknowledge before and after the countdown |
| pause_ack | input | 9 | Per-channel user acknowledge |
| pause_req | output | 9 | Per-channel pause request to user logic |

## Verification
The bound checker watches, on every cycle, these port-level rules:
- the request reads zero right after reset;
- a disabled channel with its request low never raises it;
- every accepted pause raises the request on the next cycle;
- a request never falls except on a quanta tick.

Only the bench's scenarios, compared cycle by cycle against a behavioural model, show the exact duration of each countdown. The same holds for the wait for acknowledge, the release wait with its 32-cycle fallback, reloads in each phase, and independence between channels.

// File: rtl/rxp_pkg.sv
package rxp_pkg;

    typedef enum logic [1:0] {
        CH_IDLE     = 2'd0,
        CH_ACK_WAIT = 2'd1,
        CH_COUNT    = 2'd2,
        CH_RELEASE  = 2'd3
    } ch_state_t;

endpackage

// File: rtl/rxp_quanta_tick.sv
module rxp_quanta_tick #(
    parameter int CYCLES_PER_QUANTA = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    generate
        if (CYCLES_PER_QUANTA <= 1) begin : g_every
            assign tick = 1'b1;
        end else begin : g_div
            localparam int CW = $clog2(CYCLES_PER_QUANTA);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst) begin
                    cnt <= '0;
                end else if (cnt == CW'(CYCLES_PER_QUANTA - 1)) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = (cnt == CW'(CYCLES_PER_QUANTA - 1));
        end
    endgenerate
endmodule

// File: rtl/rxp_channel.sv
module rxp_channel
    import rxp_pkg::*;
#(
    parameter int QW             = 16,
    parameter int RELEASE_CYCLES = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          pulse,
    input  logic [QW-1:0] quanta,
    input  logic          en,
    input  logic          ack_mode,
    input  logic          ack,
    output logic          req
);
    localparam int RCW = (RELEASE_CYCLES > 1) ? $clog2(RELEASE_CYCLES) : 1;

    ch_state_t     st, st_nxt;
    logic [QW-1:0] tmr;
    logic [RCW-1:0] rel_cnt;
    logic          take;
    logic          tmr_load, tmr_dec, tmr_clr, rel_inc;

    assign take = pulse && en;

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= CH_IDLE;
        else     st <= st_nxt;
    end

    // next state and datapath controls
    always_comb begin
        st_nxt   = st;
        tmr_load = 1'b0;
        tmr_dec  = 1'b0;
        tmr_clr  = 1'b0;
        rel_inc  = 1'b0;
        unique case (st)
            CH_IDLE: begin
                if (take) begin
                    tmr_load = 1'b1;
                    st_nxt   = ack_mode ? CH_ACK_WAIT : CH_COUNT;
                end
            end
            CH_ACK_WAIT: begin
                if (take) tmr_load = 1'b1;
                if (ack || !ack_mode) st_nxt = CH_COUNT;
            end
            CH_COUNT: begin
                if (take) begin
                    tmr_load = 1'b1;
                end else if (tick) begin
                    if (tmr <= QW'(1)) begin
                        tmr_clr = 1'b1;
                        st_nxt  = ack_mode ? CH_RELEASE : CH_IDLE;
                    end else begin
                        tmr_dec = 1'b1;
                    end
                end
            end
            CH_RELEASE: begin
                if (take) begin
                    tmr_load = 1'b1;
                    st_nxt   = CH_COUNT;
                end else if (!ack || !ack_mode) begin
                    st_nxt = CH_IDLE;
                end else if (rel_cnt == RCW'(RELEASE_CYCLES - 1)) begin
                    st_nxt = CH_IDLE;
                end else begin
                    rel_inc = 1'b1;
                end
            end
            default: st_nxt = CH_IDLE;
        endcase
    end

    // quanta timer
    always_ff @(posedge clk) begin
        if (rst || tmr_clr) tmr <= '0;
        else if (tmr_load)  tmr <= quanta;
        else if (tmr_dec)   tmr <= tmr - 1'b1;
    end

    // release-wait timeout counter
    always_ff @(posedge clk) begin
        if (rst || st != CH_RELEASE) rel_cnt <= '0;
        else if (rel_inc)            rel_cnt <= rel_cnt + 1'b1;
    end

    // outputs
    always_comb begin
        req = (st == CH_ACK_WAIT) || (st == CH_COUNT);
    end
endmodule

// File: rtl/rxp_pause_ctrl.sv
module rxp_pause_ctrl #(
    parameter int NUM_CH            = 9,
    parameter int QW                = 16,
    parameter int CYCLES_PER_QUANTA = 4,
    parameter int RELEASE_CYCLES    = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_CH-1:0]    pause_rx_vld,
    input  logic [NUM_CH*QW-1:0] pause_rx_quanta,
    input  logic [NUM_CH-1:0]    pause_en,
    input  logic                 ack_check_mode,
    input  logic [NUM_CH-1:0]    pause_ack,
    output logic [NUM_CH-1:0]    pause_req
);
    logic q_tick;

    rxp_quanta_tick #(
        .CYCLES_PER_QUANTA(CYCLES_PER_QUANTA)
    ) u_tick (
        .clk (clk),
        .rst (rst),
        .tick(q_tick)
    );

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            rxp_channel #(
                .QW            (QW),
                .RELEASE_CYCLES(RELEASE_CYCLES)
            ) u_ch (
                .clk     (clk),
                .rst     (rst),
                .tick    (q_tick),
                .pulse   (pause_rx_vld[i]),
                .quanta  (pause_rx_quanta[i*QW +: QW]),
                .en      (pause_en[i]),
                .ack_mode(ack_check_mode),
                .ack     (pause_ack[i]),
                .req     (pause_req[i])
            );
        end
    endgenerate
endmodule

// File: rtl/rxp_pause_checker.sv
module rxp_pause_checker #(
    parameter int NUM_CH = 9
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] vld,
    input logic [NUM_CH-1:0] en,
    input logic              tick,
    input logic [NUM_CH-1:0] req
);
    // R1: request vector is clear on the first cycle out of reset
    p_reset_clear_r1: assert property (@(posedge clk)
        $fell(rst) |-> (req == '0));

    generate
        for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
            // R2: disabled pulse never raises a low request
            p_disabled_ignored_r2: assert property (@(posedge clk) disable iff (rst)
                (vld[i] && !en[i] && !req[i]) |=> !req[i]);

            // R3: accepted pulse raises request next cycle
            p_accept_raises_r3: assert property (@(posedge clk) disable iff (rst)
                (vld[i] && en[i]) |=> req[i]);

            // R3: request only rises on an accepted pulse
            p_rise_needs_pulse_r3: assert property (@(posedge clk) disable iff (rst)
                (!req[i] && !(vld[i] && en[i])) |=> !req[i]);

            // R5: request only falls following a quanta tick
            p_fall_on_tick_r5: assert property (@(posedge clk) disable iff (rst)
                (req[i] && !tick) |=> req[i]);
        end
    endgenerate
endmodule

bind rxp_pause_ctrl rxp_pause_checker #(.NUM_CH(NUM_CH)) u_rxp_chk (
    .clk (clk),
    .rst (rst),
    .vld (pause_rx_vld),
    .en  (pause_en),
    .tick(q_tick),
    .req (pause_req)
);

// File: tb/tb_rxp_pause_ctrl.sv
module tb_rxp_pause_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 9;
    localparam int QW   = 16;
    localparam int CPQ  = 4;
    localparam int RELN = 32;

    logic                clk = 1'b0;
    logic                rst;
    logic [NCH-1:0]      vld;
    logic [NCH*QW-1:0]   quanta;
    logic [NCH-1:0]      en;
    logic                mode;
    logic [NCH-1:0]      ack;
    logic [NCH-1:0]      req;

    int checks = 0;
    int failures = 0;
    string cur_tag = "R1";

    // behavioural model: 0 idle, 1 waiting for ack, 2 counting, 3 release wait
    int m_st [NCH];
    int m_tmr[NCH];
    int m_rc [NCH];
    int m_pc;

    rxp_pause_ctrl #(
        .NUM_CH(NCH), .QW(QW), .CYCLES_PER_QUANTA(CPQ), .RELEASE_CYCLES(RELN)
    ) dut (
        .clk(clk), .rst(rst), .pause_rx_vld(vld), .pause_rx_quanta(quanta),
        .pause_en(en), .ack_check_mode(mode), .pause_ack(ack), .pause_req(req)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [NCH-1:0] model_req();
        logic [NCH-1:0] r;
        for (int c = 0; c < NCH; c++) r[c] = (m_st[c] == 1 || m_st[c] == 2);
        return r;
    endfunction

    task automatic model_step();
        bit tk;
        tk = (m_pc == CPQ - 1);
        if (rst) begin
            m_pc = 0;
            for (int c = 0; c < NCH; c++) begin m_st[c] = 0; m_tmr[c] = 0; m_rc[c] = 0; end
            return;
        end
        m_pc = tk ? 0 : m_pc + 1;
        for (int c = 0; c < NCH; c++) begin
            bit take;
            int q;
            take = vld[c] && en[c];
            q = int'(quanta[c*QW +: QW]);
            if (m_st[c] == 0) begin
                if (take) begin m_tmr[c] = q; m_st[c] = mode ? 1 : 2; end
            end else if (m_st[c] == 1) begin
                if (take) m_tmr[c] = q;
                if (ack[c] || !mode) m_st[c] = 2;
            end else if (m_st[c] == 2) begin
                if (take) m_tmr[c] = q;
                else if (tk) begin
                    if (m_tmr[c] <= 1) begin
                        m_tmr[c] = 0;
                        m_rc[c] = 0;
                        m_st[c] = mode ? 3 : 0;
                    end else m_tmr[c]--;
                end
            end else begin
                if (take) begin m_tmr[c] = q; m_st[c] = 2; end
                else if (!ack[c] || !mode) m_st[c] = 0;
                else if (m_rc[c] == RELN - 1) m_st[c] = 0;
                else m_rc[c]++;
            end
        end
    endtask

    task automatic chk(input logic got, input logic exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic cyc();
        logic [NCH-1:0] e;
        @(posedge clk);
        model_step();
        @(negedge clk);
        e = model_req();
        checks++;
        if (req !== e) begin
            failures++;
            $display("FAIL %s: pause_req got %b expected %b at %0t", cur_tag, req, e, $time);
        end
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic send(input int c, input int q);
        vld[c] = 1'b1;
        quanta[c*QW +: QW] = QW'(q);
        cyc();
        vld[c] = 1'b0;
    endtask

    // waits for request c to fall within maxc cycles; returns cycles waited
    task automatic wait_drop(input int c, input int maxc, input string tag, output int n);
        n = 0;
        while (req[c] && n < maxc) begin cyc(); n++; end
        chk(req[c], 1'b0, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        rst = 1'b1; vld = '0; quanta = '0; en = '1; mode = 1'b0; ack = '0;
        m_pc = 0;
        for (int c = 0; c < NCH; c++) begin m_st[c] = 0; m_tmr[c] = 0; m_rc[c] = 0; end
        run(3);
        rst = 1'b0;
        cyc();
        chk(req == '0, 1'b1, "R1");

        // R2: disabled channel discards pause
        cur_tag = "R2";
        en[3] = 1'b0;
        send(3, 5);
        run(3);
        chk(req[3], 1'b0, "R2");
        en[3] = 1'b1;

        // R3/R5: mode 0, quanta 3
        cur_tag = "R5";
        send(0, 3);
        chk(req[0], 1'b1, "R3");
        wait_drop(0, 3*CPQ + 2, "R5", n);
        chk(n >= 2*CPQ - 1, 1'b1, "R5");
        run(2);

        // R5: zero quanta ends on the next tick
        send(1, 0);
        chk(req[1], 1'b1, "R3");
        wait_drop(1, CPQ + 1, "R5", n);
        run(2);

        // R4/R6: ack-check mode, ack held back
        cur_tag = "R4";
        mode = 1'b1;
        send(8, 2);
        run(30);
        chk(req[8], 1'b1, "R4");
        ack[8] = 1'b1;
        cur_tag = "R6";
        wait_drop(8, 2*CPQ + 3, "R4", n);
        run(10);
        ack[8] = 1'b0;
        run(3);

        // R6: ack never released -> 32-cycle fallback
        ack[7] = 1'b1;
        send(7, 1);
        wait_drop(7, CPQ + 3, "R6", n);
        run(RELN + 6);
        chk(req[7], 1'b0, "R6");
        send(7, 1);
        chk(req[7], 1'b1, "R6");
        wait_drop(7, CPQ + 4, "R6", n);
        run(RELN + 2);
        ack[7] = 1'b0;
        run(2);

        // R7: reload while counting (mode 0)
        cur_tag = "R7";
        mode = 1'b0;
        send(2, 2);
        run(3);
        send(2, 6);
        run(8);
        chk(req[2], 1'b1, "R7");
        wait_drop(2, 6*CPQ + 2, "R7", n);
        run(2);

        // R7: reload during release wait reasserts without new ack edge
        mode = 1'b1;
        ack[4] = 1'b1;
        send(4, 1);
        wait_drop(4, CPQ + 3, "R7", n);
        run(5);
        send(4, 3);
        chk(req[4], 1'b1, "R7");
        wait_drop(4, 3*CPQ + 2, "R7", n);
        ack[4] = 1'b0;
        run(3);

        // R8: enable cleared mid-sequence
        cur_tag = "R8";
        mode = 1'b0;
        send(5, 4);
        en[5] = 1'b0;
        run(5);
        chk(req[5], 1'b1, "R8");
        send(5, 20);
        wait_drop(5, 4*CPQ + 2, "R8", n);
        en[5] = 1'b1;
        run(2);

        // R9: independent channels, simultaneous pauses
        cur_tag = "R9";
        vld[6] = 1'b1; quanta[6*QW +: QW] = 16'd1;
        vld[0] = 1'b1; quanta[0 +: QW] = 16'd5;
        cyc();
        vld = '0;
        run(2*CPQ + 2);
        chk(req[6], 1'b0, "R9");
        chk(req[0], 1'b1, "R9");
        wait_drop(0, 5*CPQ, "R9", n);
        run(4);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule